// File: doc/BRIEF.md
# PCI Memory Window Address Translator

This block maps system-bus accesses that land in one of three fixed-size memory apertures onto 32-bit PCI memory addresses. Software sets each aperture's PCI base through its own 32-bit base register. A second set of three 32-bit registers is kept for software and only stores values. A fourth selector value chooses a fixed I/O aperture of 1 MiB, which always starts at PCI I/O address 0.

The caller gives a window number and a byte offset into that window. The block returns the PCI address and a hit flag at once, through combinational logic that reads the current register state. A static variant input picks one of two ways to read the base registers, and each way has its own set of window sizes. With variant 0, bits [3:0] of the base register become PCI address bits [31:28], and the windows are 0x0C000000, 0x10000000 and 0x10000000 bytes long. With variant 1, the register bits at and above the window size give the upper address bits, and the windows are 0x01000000, 0x04000000 and 0x08000000 bytes long.

Top module: `pcw_xlate`

## Requirements
- R1: After reset all six registers read zero, and a hit in any memory window returns the bare offset as the PCI address.
- R2: A register access with word_i low raises err_o while req_i is high, and changes no register.
- R3: The register map holds base registers 0..2 at byte offsets 0x00, 0x04 and 0x08, and store registers 0..2 at 0x10, 0x14 and 0x18. Any other offset, misaligned ones included, raises err_o, reads as zero, and changes no register.
- R4: A word write to a store register reads back all 32 bits unchanged.
- R5: A word write to a base register reads back all 32 bits unchanged.
- R6: With variant_i = 0, the PCI address of a hit is {base[3:0], 28'h0} plus the offset. Base register bits [31:4] are ignored.
- R7: With variant_i = 1, the PCI address of a hit is (base AND NOT(size-1)) plus the offset.
- R8: Window sizes are 0x0C000000, 0x10000000 and 0x10000000 for variant 0, and 0x01000000, 0x04000000 and 0x08000000 for variant 1. An offset at or past the size clears hit_o and drives pci_addr_o to 0.
- R9: win_sel_i = 3 selects the I/O window. It hits for offsets below 0x100000, returns the offset as the address, and raises pci_io_o. Memory windows keep pci_io_o low.
- R10: A base register write is seen by translation from the clock edge that performs it. Before that edge the old base still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 1 | 0: base nibble into bits [31:28]; 1: masked upper bits |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | Access is a full 32-bit word |
| reg_addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as the request |
| err_o | output | 1 | Access rejected |
| win_sel_i | input | 2 | 0..2 memory window, 3 I/O window |
| win_off_i | input | 32 | Byte offset into the selected window |
| pci_addr_o | output | 32 | Translated PCI address, 0 on a miss |
| hit_o | output | 1 | Offset lies inside the window |
| pci_io_o | output | 1 | Result is in PCI I/O space |

## Verification
Read data, err_o and every translation output are combinational. They are due in the same cycle the inputs are applied, so the bench drives inputs at the falling edge and samples one time unit later, before the next rising edge. Register writes land on the next rising edge. Read-back and translation checks after a write are therefore made in the following low phase. For R10 the window inputs are held steady, and the old address is checked in the low phase that carries the write and the new address just after the write edge.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int unsigned DATA_W = 32;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic {
    VAR_NIBBLE = 1'b0,
    VAR_MASKED = 1'b1
  } variant_e;
endpackage

// File: rtl/pcw_regfile.sv
module pcw_regfile
  import pcw_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 3,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_OFS  = 'h00,
  parameter logic [ADDR_W-1:0] STORE_OFS = 'h10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic                      word_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  word_t                     wdata_i,
  output word_t                     rdata_o,
  output logic                      err_o,
  output logic [NUM_WIN-1:0][DATA_W-1:0] base_o
);
  localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [NUM_WIN-1:0][DATA_W-1:0] base_q, store_q;
  logic [ADDR_W-1:0] base_rel, store_rel;
  logic base_sel, store_sel, addr_ok, wr_en;
  logic [IDX_W-1:0] base_idx, store_idx;

  assign base_rel  = addr_i - BASE_OFS;
  assign store_rel = addr_i - STORE_OFS;
  assign base_sel  = (addr_i >= BASE_OFS) && (base_rel[1:0] == 2'b00)
                     && ((base_rel >> 2) < ADDR_W'(NUM_WIN));
  assign store_sel = (addr_i >= STORE_OFS) && (store_rel[1:0] == 2'b00)
                     && ((store_rel >> 2) < ADDR_W'(NUM_WIN));
  assign base_idx  = IDX_W'(base_rel >> 2);
  assign store_idx = IDX_W'(store_rel >> 2);
  assign addr_ok   = base_sel || store_sel;
  assign wr_en     = req_i && we_i && word_i && addr_ok;
  assign err_o     = req_i && (!word_i || !addr_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      store_q <= '0;
    end else if (wr_en) begin
      if (base_sel)  base_q[base_idx]   <= wdata_i;
      if (store_sel) store_q[store_idx] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && word_i) begin
      if (base_sel)       rdata_o = base_q[base_idx];
      else if (store_sel) rdata_o = store_q[store_idx];
    end
  end

  assign base_o = base_q;

  p_narrow_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !word_i) |=> ($stable(base_q) && $stable(store_q)));

  p_bad_ofs_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !addr_ok) |=> ($stable(base_q) && $stable(store_q)));

  p_store_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && store_sel) |=> (store_q[$past(store_idx)] == $past(wdata_i)));

  p_base_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && base_sel) |=> (base_q[$past(base_idx)] == $past(wdata_i)));
endmodule

// File: rtl/pcw_window.sv
module pcw_window
  import pcw_pkg::*;
#(
  parameter word_t SIZE_NIB = 32'h1000_0000,
  parameter word_t SIZE_MSK = 32'h0100_0000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  variant_i,
  input  word_t base_reg_i,
  input  word_t off_i,
  output word_t addr_o,
  output logic  hit_o
);
  word_t size, base;

  always_comb begin
    if (variant_e'(variant_i) == VAR_MASKED) begin
      size = SIZE_MSK;
      base = base_reg_i & ~(SIZE_MSK - 32'd1);
    end else begin
      size = SIZE_NIB;
      base = {base_reg_i[3:0], 28'h0};
    end
  end

  assign hit_o  = off_i < size;
  assign addr_o = hit_o ? (base + off_i) : '0;

  // nibble variant: windows never exceed 256 MiB, so the top nibble is the register's
  p_nibble_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!variant_i && hit_o) |-> (addr_o[31:28] == base_reg_i[3:0]));

  p_masked_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i && hit_o) |-> (((addr_o ^ base_reg_i) & ~(SIZE_MSK - 32'd1)) == '0));

  p_miss_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (off_i >= (variant_i ? SIZE_MSK : SIZE_NIB)));
endmodule

// File: rtl/pcw_xlate.sv
module pcw_xlate
  import pcw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [NUM_WIN*DATA_W-1:0] SIZES_NIB =
    {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
  parameter logic [NUM_WIN*DATA_W-1:0] SIZES_MSK =
    {32'h0800_0000, 32'h0400_0000, 32'h0100_0000},
  parameter word_t IO_SIZE = 32'h0010_0000,
  localparam int unsigned SEL_W = $clog2(NUM_WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic [SEL_W-1:0]  win_sel_i,
  input  logic [31:0]       win_off_i,
  output logic [31:0]       pci_addr_o,
  output logic              hit_o,
  output logic              pci_io_o
);
  logic [NUM_WIN-1:0][DATA_W-1:0] base_regs;
  word_t win_addr [NUM_WIN];
  logic  [NUM_WIN-1:0] win_hit;
  logic  io_sel;

  pcw_regfile #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .word_i  (word_i),
    .addr_i  (reg_addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .err_o   (err_o),
    .base_o  (base_regs)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    pcw_window #(
      .SIZE_NIB (SIZES_NIB[w*DATA_W +: DATA_W]),
      .SIZE_MSK (SIZES_MSK[w*DATA_W +: DATA_W])
    ) u_win (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .variant_i  (variant_i),
      .base_reg_i (base_regs[w]),
      .off_i      (win_off_i),
      .addr_o     (win_addr[w]),
      .hit_o      (win_hit[w])
    );
  end

  assign io_sel = (win_sel_i == SEL_W'(NUM_WIN));

  always_comb begin
    pci_addr_o = '0;
    hit_o      = 1'b0;
    pci_io_o   = 1'b0;
    if (io_sel) begin
      pci_io_o = 1'b1;
      if (win_off_i < IO_SIZE) begin
        hit_o      = 1'b1;
        pci_addr_o = win_off_i;
      end
    end else if (win_sel_i < SEL_W'(NUM_WIN)) begin
      hit_o      = win_hit[win_sel_i];
      pci_addr_o = win_addr[win_sel_i];
    end
  end

  p_io_identity_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel && hit_o) |-> (pci_addr_o == win_off_i));

  p_mem_not_io_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_sel |-> !pci_io_o);
endmodule

// File: tb/pcw_xlate_tb.sv
module pcw_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        variant = 1'b0;
  logic        req = 1'b0, we = 1'b0, word = 1'b1;
  logic [11:0] reg_addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [1:0]  win_sel = '0;
  logic [31:0] win_off = '0;
  logic [31:0] pci_addr;
  logic        hit, pci_io;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcw_xlate u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .variant_i  (variant),
    .req_i      (req),
    .we_i       (we),
    .word_i     (word),
    .reg_addr_i (reg_addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .err_o      (err),
    .win_sel_i  (win_sel),
    .win_off_i  (win_off),
    .pci_addr_o (pci_addr),
    .hit_o      (hit),
    .pci_io_o   (pci_io)
  );

  function automatic logic [31:0] wsize(input logic v, input int w);
    if (!v) return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    case (w)
      0: return 32'h0100_0000;
      1: return 32'h0400_0000;
      default: return 32'h0800_0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(input logic v, input int w,
                                           input logic [31:0] b, input logic [31:0] o);
    logic [31:0] s = wsize(v, w);
    if (o >= s) return 32'h0;
    if (!v) return {b[3:0], 28'h0} + o;
    return (b & ~(s - 32'd1)) + o;
  endfunction

  task automatic chk(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req_tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d, input logic wd,
                        output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b1; word = wd; reg_addr = a; wdata = d;
    #1 e = err;
    @(negedge clk);
    req = 1'b0; we = 1'b0; word = 1'b1;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b0; word = 1'b1; reg_addr = a;
    #1 begin d = rdata; e = err; end
    req = 1'b0;
  endtask

  task automatic xlate(input logic v, input logic [1:0] s, input logic [31:0] o);
    @(negedge clk);
    variant = v; win_sel = s; win_off = o;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    for (int i = 0; i < 3; i++) begin
      reg_rd(12'(4*i), d, e);         chk("R1 base reset", d, 0);
      reg_rd(12'(16 + 4*i), d, e);    chk("R1 store reset", d, 0);
    end
    for (int w = 0; w < 3; w++) begin
      xlate(1'b0, 2'(w), 32'h0000_1234); chk("R1 zero base addr", pci_addr, 32'h0000_1234);
      xlate(1'b1, 2'(w), 32'h0000_0ABC); chk("R1 zero base addr v1", pci_addr, 32'h0000_0ABC);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d; logic e;
    reg_wr(12'h014, 32'hDEAD_BEEF, 1'b1, e); chk("R4 write err", 32'(e), 0);
    reg_wr(12'h018, 32'h0123_4567, 1'b1, e);
    reg_rd(12'h014, d, e); chk("R4 store1 readback", d, 32'hDEAD_BEEF);
    reg_rd(12'h018, d, e); chk("R4 store2 readback", d, 32'h0123_4567);
    reg_wr(12'h004, 32'hCAFE_F00D, 1'b1, e);
    reg_rd(12'h004, d, e); chk("R5 base1 readback", d, 32'hCAFE_F00D);
    chk("R5 read err", 32'(e), 0);
  endtask

  task automatic t_narrow();
    logic [31:0] d; logic e;
    reg_wr(12'h014, 32'h5555_AAAA, 1'b0, e); chk("R2 narrow write err", 32'(e), 1);
    reg_rd(12'h014, d, e);                   chk("R2 store unchanged", d, 32'hDEAD_BEEF);
    reg_wr(12'h004, 32'h1111_1111, 1'b0, e);
    reg_rd(12'h004, d, e);                   chk("R2 base unchanged", d, 32'hCAFE_F00D);
  endtask

  task automatic t_badofs();
    logic [31:0] d; logic e;
    reg_wr(12'h00C, 32'h7777_7777, 1'b1, e); chk("R3 gap write err", 32'(e), 1);
    reg_wr(12'h006, 32'h8888_8888, 1'b1, e); chk("R3 misaligned err", 32'(e), 1);
    reg_rd(12'h00C, d, e); chk("R3 gap read zero", d, 0); chk("R3 gap read err", 32'(e), 1);
    reg_rd(12'h004, d, e); chk("R3 base1 unchanged", d, 32'hCAFE_F00D);
    reg_rd(12'h008, d, e); chk("R3 base2 unchanged", d, 0);
    reg_rd(12'h01C, d, e); chk("R3 past store err", 32'(e), 1);
  endtask

  task automatic t_nibble();
    logic e;
    reg_wr(12'h000, 32'hABCD_0005, 1'b1, e);
    reg_wr(12'h008, 32'h0000_000F, 1'b1, e);
    xlate(1'b0, 2'd0, 32'h0123_4567);
    chk("R6 win0 addr", pci_addr, exp_addr(1'b0, 0, 32'hABCD_0005, 32'h0123_4567));
    xlate(1'b0, 2'd2, 32'h0FFF_FFFF);
    chk("R6 win2 top addr", pci_addr, 32'hFFFF_FFFF);
    xlate(1'b0, 2'd1, 32'h0000_0100);
    chk("R6 win1 addr", pci_addr, exp_addr(1'b0, 1, 32'hCAFE_F00D, 32'h0000_0100));
  endtask

  task automatic t_masked();
    logic e;
    reg_wr(12'h004, 32'h9876_5432, 1'b1, e);
    xlate(1'b1, 2'd1, 32'h0123_4567);
    chk("R7 win1 addr", pci_addr, 32'h9923_4567);
    xlate(1'b1, 2'd0, 32'h00FF_0000);
    chk("R7 win0 addr", pci_addr, exp_addr(1'b1, 0, 32'hABCD_0005, 32'h00FF_0000));
    xlate(1'b1, 2'd2, 32'h0700_0001);
    chk("R7 win2 addr", pci_addr, exp_addr(1'b1, 2, 32'h0000_000F, 32'h0700_0001));
  endtask

  task automatic t_bounds();
    for (int v = 0; v < 2; v++) begin
      for (int w = 0; w < 3; w++) begin
        logic [31:0] s = wsize(1'(v), w);
        xlate(1'(v), 2'(w), s - 32'd1); chk("R8 last byte hit", 32'(hit), 1);
        xlate(1'(v), 2'(w), s);         chk("R8 size miss", 32'(hit), 0);
        chk("R8 miss addr zero", pci_addr, 0);
        chk("R9 mem not io", 32'(pci_io), 0);
      end
    end
  endtask

  task automatic t_io();
    xlate(1'b0, 2'd3, 32'h000F_FFFF);
    chk("R9 io hit", 32'(hit), 1); chk("R9 io addr", pci_addr, 32'h000F_FFFF);
    chk("R9 io flag", 32'(pci_io), 1);
    xlate(1'b1, 2'd3, 32'h0010_0000);
    chk("R9 io miss", 32'(hit), 0); chk("R9 io miss addr", pci_addr, 0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    variant = 1'b0; win_sel = 2'd1; win_off = 32'h0000_0040;
    req = 1'b1; we = 1'b1; word = 1'b1; reg_addr = 12'h004; wdata = 32'h0000_0003;
    #1 chk("R10 old base before edge", pci_addr, 32'h2000_0040);
    @(posedge clk);
    #1 chk("R10 new base after edge", pci_addr, 32'h3000_0040);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_narrow();
    t_badofs();
    t_nibble();
    t_masked();
    t_bounds();
    t_io();
    t_timing();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule